// File: doc/BRIEF.md
# Faulty-Row Match Address Remapper

A ternary CAM with some rows marked faulty can still resolve its priority and encode its match address as if all rows were healthy. This block sits after the encoder and turns that physical match address into the logical address software expects. The logical address is the physical one minus the number of faulty rows that rank above the match. Lower addresses rank higher, so a faulty row ranks above the match when its address is numerically smaller.

A small register file holds the faulty row addresses. Each entry has a valid bit and is loaded through a simple write port. Every valid entry is compared in parallel against the incoming match address. The comparators that report "smaller than the match" are counted, and that count is subtracted from the address. The corrected address, the hit flag and an error flag all come out registered, one cycle after the input. The error flag is raised when a valid faulty entry equals the match address, because a row that has been disabled should never produce a match.

Top module: `tcam_row_remap`

## Requirements
- R1: While reset is asserted and after it is released, all outputs are 0 and every table entry is invalid. The first hit after reset therefore passes through unchanged.
- R2: A write with `cfg_we`=1 stores `cfg_addr` and `cfg_valid` into entry `cfg_idx`. A hit presented in the same cycle as the write still sees the old entry; hits in later cycles see the new one. Writing with `cfg_valid`=0 removes the entry. An index of ENTRIES or more is ignored.
- R3: If no valid entry holds an address smaller than the hit address, the output address equals the hit address.
- R4: Otherwise, the output address is the hit address minus the number of valid entries whose address is strictly smaller than it.
- R5: Entries whose valid bit is 0 take no part in the count or in the error check, whatever address they hold.
- R6: Several faulty rows are corrected together. Every valid entry below the match adds one to the count, and all ENTRIES entries may be valid at the same time.
- R7: `hit_valid_o` is `hit_valid_i` delayed by one clock. The address and error outputs for a hit appear in the same cycle as the delayed flag.
- R8: `hit_err_o` is 1 when a valid entry equals the hit address. The equal entry does not count towards the subtraction.
- R9: In a cycle after `hit_valid_i` was 0, `hit_addr_o` and `hit_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Table entry index for the write |
| cfg_addr | input | ADDR_W | Faulty row address to store |
| cfg_valid | input | 1 | Valid bit to store with the address |
| hit_valid_i | input | 1 | Encoded match present |
| hit_addr_i | input | ADDR_W | Physical match address from the encoder |
| hit_valid_o | output | 1 | Registered match present |
| hit_addr_o | output | ADDR_W | Logical (corrected) match address |
| hit_err_o | output | 1 | Match landed on a row listed as faulty |

## Verification
The bench builds the block with ADDR_W=6 and ENTRIES=4. With these values the table can be filled completely, and both ends of the address range (0 and 63) can be driven. At 63 the full count of four is subtracted. The narrow table also makes it cheap to test an invalid entry that sits below the match, an entry that equals the match, a table write in the same cycle as a search, and the removal of an entry.

// File: rtl/tcam_remap_pkg.sv
package tcam_remap_pkg;

    // Flags carried through the output register.
    typedef struct packed {
        logic valid;
        logic err;
    } hit_flags_t;

    function automatic int unsigned cnt_width(input int unsigned entries);
        return $clog2(entries + 1);
    endfunction

endpackage

// File: rtl/tcam_fault_table.sv
module tcam_fault_table #(
    parameter int ADDR_W  = 9,
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic                              wr_valid,
    output logic [ENTRIES-1:0]                ent_vld,
    output logic [ENTRIES-1:0][ADDR_W-1:0]    ent_addr
);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic idx_ok;

    assign idx_ok = (32'(wr_idx) < 32'(ENTRIES));

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && idx_ok) begin
            tbl_d.vld[wr_idx]  = wr_valid;
            tbl_d.addr[wr_idx] = wr_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign ent_vld  = tbl_q.vld;
    assign ent_addr = tbl_q.addr;

    // R2: a write lands in the addressed entry on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_ok) |=> (ent_vld[$past(wr_idx)] == $past(wr_valid)) &&
                              (ent_addr[$past(wr_idx)] == $past(wr_addr)));

    // R2: entries hold without a write
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ent_vld));

endmodule

// File: rtl/tcam_fault_cmp.sv
module tcam_fault_cmp #(
    parameter int ADDR_W  = 9,
    parameter int ENTRIES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ENTRIES-1:0]                ent_vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]    ent_addr,
    input  logic [ADDR_W-1:0]                 key,
    output logic [ENTRIES-1:0]                above,
    output logic [ENTRIES-1:0]                same
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic lt_raw, eq_raw;
        assign lt_raw   = (ent_addr[g] < key);
        assign eq_raw   = (ent_addr[g] == key);
        assign above[g] = ent_vld[g] & lt_raw;
        assign same[g]  = ent_vld[g] & eq_raw;
    end

    // R5: disabled entries never report
    p_invalid_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((above | same) & ~ent_vld) == '0);

    // R8: an entry can't be both strictly above and equal
    p_lt_eq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (above & same) == '0);

endmodule

// File: rtl/tcam_popcount.sv
module tcam_popcount #(
    parameter int N     = 8,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     bits_i,
    output logic [CNT_W-1:0] count_o
);

    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + CNT_W'(bits_i[i]);
        end
    end

endmodule

// File: rtl/tcam_row_remap.sv
module tcam_row_remap
    import tcam_remap_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_valid,
    input  logic              hit_valid_i,
    input  logic [ADDR_W-1:0] hit_addr_i,
    output logic              hit_valid_o,
    output logic [ADDR_W-1:0] hit_addr_o,
    output logic              hit_err_o
);

    localparam int CNT_W = cnt_width(ENTRIES);

    typedef struct packed {
        hit_flags_t        flg;
        logic [ADDR_W-1:0] addr;
    } out_t;

    logic [ENTRIES-1:0]             ent_vld;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [ENTRIES-1:0]             above, same;
    logic [CNT_W-1:0]               n_above;
    out_t out_d, out_q;

    tcam_fault_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_addr  (cfg_addr),
        .wr_valid (cfg_valid),
        .ent_vld  (ent_vld),
        .ent_addr (ent_addr)
    );

    tcam_fault_cmp #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent_vld  (ent_vld),
        .ent_addr (ent_addr),
        .key      (hit_addr_i),
        .above    (above),
        .same     (same)
    );

    tcam_popcount #(.N(ENTRIES), .CNT_W(CNT_W)) u_pop (
        .bits_i  (above),
        .count_o (n_above)
    );

    always_comb begin
        out_d = '0;
        out_d.flg.valid = hit_valid_i;
        if (hit_valid_i) begin
            out_d.addr    = hit_addr_i - ADDR_W'(n_above);
            out_d.flg.err = |same;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hit_valid_o = out_q.flg.valid;
    assign hit_addr_o  = out_q.addr;
    assign hit_err_o   = out_q.flg.err;

    // R7: valid flag is delayed by exactly one cycle
    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid_i |=> hit_valid_o);

    // R9: idle cycles give zero address and no error
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid_o |-> (hit_addr_o == '0) && !hit_err_o);

    // R3: nothing above the match means pass-through
    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid_i && (above == '0)) |=> hit_addr_o == $past(hit_addr_i));

    // R4: correction never raises the address
    p_no_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid_i |=> hit_addr_o <= $past(hit_addr_i));

    // R8: a faulty entry equal to the match raises the error
    p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid_i && (same != '0)) |=> hit_err_o);

endmodule

// File: tb/tcam_row_remap_bench.sv
module tcam_row_remap_bench;

    localparam int AW = 6;
    localparam int NE = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_valid = 1'b0;
    logic          hit_valid_i = 1'b0;
    logic [AW-1:0] hit_addr_i = '0;
    logic          hit_valid_o;
    logic [AW-1:0] hit_addr_o;
    logic          hit_err_o;

    always #2.5 clk = ~clk;

    tcam_row_remap #(.ADDR_W(AW), .ENTRIES(NE), .IDX_W(IW)) u_tcam_row_remap (
        .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_addr, .cfg_valid,
        .hit_valid_i, .hit_addr_i, .hit_valid_o, .hit_addr_o, .hit_err_o
    );

    typedef struct {
        logic          vld;
        logic [AW-1:0] addr;
        logic          err;
        string         req;
    } item_t;

    item_t   sb[$];
    int      n_vec = 0;
    int      n_bad = 0;
    bit      done = 0;
    logic          m_vld [NE];
    logic [AW-1:0] m_addr[NE];

    function automatic item_t model(input logic v, input logic [AW-1:0] a, input string r);
        item_t it;
        int    c = 0;
        it.vld = v; it.addr = '0; it.err = 1'b0; it.req = r;
        if (v) begin
            for (int i = 0; i < NE; i++) begin
                if (m_vld[i] && m_addr[i] < a) c++;
                if (m_vld[i] && m_addr[i] == a) it.err = 1'b1;
            end
            it.addr = a - AW'(c);
        end
        return it;
    endfunction

    // One cycle: optional write plus optional hit; expected uses the table before the write.
    task automatic cycle(input logic we, input int idx, input logic [AW-1:0] wa, input logic wv,
                         input logic hv, input logic [AW-1:0] ha, input string r);
        @(negedge clk);
        sb.push_back(model(hv, ha, r));
        cfg_we = we; cfg_idx = IW'(idx); cfg_addr = wa; cfg_valid = wv;
        hit_valid_i = hv; hit_addr_i = ha;
        if (we && idx < NE) begin
            m_vld[idx] = wv; m_addr[idx] = wa;
        end
    endtask

    task automatic hit(input logic [AW-1:0] a, input string r);
        cycle(1'b0, 0, '0, 1'b0, 1'b1, a, r);
    endtask

    task automatic wr(input int idx, input logic [AW-1:0] a, input logic v, input string r);
        cycle(1'b1, idx, a, v, 1'b0, '0, r);
    endtask

    task automatic idle(input string r);
        cycle(1'b0, 0, '0, 1'b0, 1'b0, '0, r);
    endtask

    // Monitor: compares one item per clock, one time step after the edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            n_vec++;
            if (hit_valid_o !== e.vld || hit_addr_o !== e.addr || hit_err_o !== e.err) begin
                n_bad++;
                $display("FAIL %s: got v=%0b a=%0d e=%0b, expected v=%0b a=%0d e=%0b",
                         e.req, hit_valid_o, hit_addr_o, hit_err_o, e.vld, e.addr, e.err);
            end
        end
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin m_vld[i] = 1'b0; m_addr[i] = '0; end
        // R1: outputs held at zero during reset
        repeat (3) @(negedge clk);
        n_vec++;
        if (hit_valid_o !== 1'b0 || hit_addr_o !== '0 || hit_err_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b a=%0d e=%0b, expected 0 0 0", hit_valid_o, hit_addr_o, hit_err_o);
        end
        rst_n = 1'b1;
        hit(6'd10, "R1");            // empty table: pass-through
        idle("R9");
        hit(6'd63, "R3");
        // fill table: 5, 20, 40 valid; 30 invalid
        wr(0, 6'd5,  1'b1, "R2");
        wr(1, 6'd20, 1'b1, "R2");
        wr(2, 6'd40, 1'b1, "R2");
        wr(3, 6'd30, 1'b0, "R5");
        hit(6'd3,  "R3");            // all faulty rows below priority -> 3
        hit(6'd5,  "R8");            // equal to 5 -> err, 5
        hit(6'd21, "R4");            // 21-2 = 19
        hit(6'd20, "R8");            // err, 20-1 = 19
        hit(6'd50, "R5");            // invalid 30 ignored: 47
        hit(6'd0,  "R3");
        idle("R9");
        // write in same cycle as a hit: old contents apply
        cycle(1'b1, 3, 6'd30, 1'b1, 1'b1, 6'd50, "R2");
        hit(6'd50, "R6");            // four below: 46
        hit(6'd63, "R6");            // 59
        hit(6'd31, "R6");            // 31-3 = 28
        hit(6'd30, "R8");
        // out-of-range index ignored is impossible at IW=2 with NE=4; remove entry 0
        wr(0, 6'd5, 1'b0, "R2");
        hit(6'd50, "R2");            // 47
        hit(6'd5,  "R5");            // removed: no err, 5 - 0
        hit(6'd6,  "R7");
        hit(6'd7,  "R7");
        idle("R9");
        idle("R9");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule